// File: doc/BRIEF.md
# Wide Integer Multiply Unit

This unit multiplies two 64-bit integer operands into an exact 128-bit product. It then adds an optional third operand and returns one 64-bit slice of the outcome, together with an overflow flag. A single opcode selects the operation. The operations are:

- a signed multiply by a 16-bit immediate;
- word (32-bit) multiplies, either returning the high product word or returning the full 64-bit product with an overflow check;
- doubleword multiplies returning the low half with an overflow check, or the high half in signed and unsigned forms;
- multiply-add operations that return the high or low half of the 128-bit sum.

The product is formed one multiplier bit per clock by a shift-and-add datapath. One pulse on `start` launches an operation, which always takes the same number of cycles. When it finishes, the unit raises `done` for one cycle. The result and flag stay on the outputs until the next operation finishes. Writing the result to a register file, and any flag handling, belong to the surrounding pipeline.

Product bits are named most-significant-first in the requirements: bit 0 of a 128-bit product is its top bit and bit 127 its least significant bit. "Low half" means bits 64 to 127 and "high half" means bits 0 to 63.

Top module: `mul_wide_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `ovf` is 0 and `done` is 0.
- R2: When `start` is high at a rising edge E and no operation is in progress, the operation is accepted. `done` is then high for exactly the one cycle after edge E+64, and `result` and `ovf` take their new values at edge E+64.
- R3: A `start` seen at edges E+1 through E+64 of an accepted operation is ignored. A `start` seen in the cycle in which `done` is high is accepted.
- R4: `result` and `ovf` keep their values in every cycle in which `done` is low.
- R5: op 0 (multiply by immediate) multiplies `rs_a` signed by the sign-extended `imm` and returns product bits 64 to 127.
- R6: op 1 (signed) and op 2 (unsigned) multiply the low 32 bits of `rs_a` and `rs_b` into a 64-bit product. The product's upper 32 bits are placed in both the upper and the lower word of `result`. The upper 32 bits of the operands have no effect.
- R7: op 3 returns the full 64-bit signed product of the low 32 bits of `rs_a` and `rs_b`. `ovf` is set when bits 0 to 32 of that 64-bit product are neither all zeros nor all ones.
- R8: op 4 returns bits 64 to 127 of the signed product of `rs_a` and `rs_b`. `ovf` is set when product bits 0 to 64 are neither all zeros nor all ones.
- R9: op 5 (signed) and op 6 (unsigned) return product bits 0 to 63 of `rs_a` times `rs_b`.
- R10: op 7 adds the sign-extended `rs_c` to the signed 128-bit product. op 8 adds the zero-extended `rs_c` to the unsigned product. Both return sum bits 0 to 63.
- R11: op 9 adds the sign-extended `rs_c` to the signed product and returns sum bits 64 to 127.
- R12: Signed operations give the exact result when either operand, or both, equals -2^63 (or -2^31 for the word forms).
- R13: op codes 10 to 15 follow the R2 timing and return `result` 0 with `ovf` 0.
- R14: `ovf` is 0 after every operation other than op 3 and op 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch strobe, taken only when idle |
| op | input | 4 | Operation code, see R5 to R13 |
| rs_a | input | 64 | First multiplicand |
| rs_b | input | 64 | Second multiplicand |
| rs_c | input | 64 | Addend for the multiply-add forms |
| imm | input | 16 | Immediate multiplier for op 0 |
| result | output | 64 | Selected 64-bit result |
| ovf | output | 1 | Overflow flag for op 3 and op 4 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: a 64-bit operand width and a 16-bit immediate. These are the values at which the extreme signed operand -2^63 and the 65-bit overflow window of op 4 can actually be reached. They are also where the 33-bit window of op 3 sits at the word boundary, and where the 64-cycle latency applies. The behavioural reference computes every result with the simulator's 128-bit arithmetic and tracks the acceptance and completion cycles. It therefore exposes sign-weight errors in the last iteration, wrong slice selection, and starts that slip in while the unit is busy.

// File: rtl/mul_wide_unit.sv
module mul_wide_unit #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [XLEN-1:0]  rs_a,
  input  logic [XLEN-1:0]  rs_b,
  input  logic [XLEN-1:0]  rs_c,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  result,
  output logic             ovf,
  output logic             done
);
  localparam int PW = 2 * XLEN;
  localparam int HW = XLEN / 2;
  localparam int CW = $clog2(XLEN + 1);

  localparam logic [3:0] OP_MULI    = 4'd0;
  localparam logic [3:0] OP_MULHW_S = 4'd1;
  localparam logic [3:0] OP_MULHW_U = 4'd2;
  localparam logic [3:0] OP_MULW_OV = 4'd3;
  localparam logic [3:0] OP_MULD_OV = 4'd4;
  localparam logic [3:0] OP_MULHD_S = 4'd5;
  localparam logic [3:0] OP_MULHD_U = 4'd6;
  localparam logic [3:0] OP_MADDH_S = 4'd7;
  localparam logic [3:0] OP_MADDH_U = 4'd8;
  localparam logic [3:0] OP_MADDL   = 4'd9;

  logic [CW-1:0]   cnt;
  logic            busy, last, sgn_q;
  logic [3:0]      op_q;
  logic [PW-1:0]   acc, mcand, addend, acc_nxt;
  logic [XLEN-1:0] mplier;

  logic [PW-1:0]   a_sx, a_zx, aw_sx, aw_zx, c_sx, c_zx;
  logic [XLEN-1:0] bw_sx, bw_zx, imm_sx;
  logic [PW-1:0]   ld_a, ld_c;
  logic [XLEN-1:0] ld_b;
  logic            ld_sgn;

  assign a_sx   = {{(PW-XLEN){rs_a[XLEN-1]}}, rs_a};
  assign a_zx   = {{(PW-XLEN){1'b0}}, rs_a};
  assign aw_sx  = {{(PW-HW){rs_a[HW-1]}}, rs_a[HW-1:0]};
  assign aw_zx  = {{(PW-HW){1'b0}}, rs_a[HW-1:0]};
  assign c_sx   = {{(PW-XLEN){rs_c[XLEN-1]}}, rs_c};
  assign c_zx   = {{(PW-XLEN){1'b0}}, rs_c};
  assign bw_sx  = {{(XLEN-HW){rs_b[HW-1]}}, rs_b[HW-1:0]};
  assign bw_zx  = {{(XLEN-HW){1'b0}}, rs_b[HW-1:0]};
  assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    ld_a   = '0;
    ld_b   = '0;
    ld_c   = '0;
    ld_sgn = 1'b0;
    case (op)
      OP_MULI:                 begin ld_a = a_sx;  ld_b = imm_sx; ld_sgn = 1'b1; end
      OP_MULHW_S, OP_MULW_OV:  begin ld_a = aw_sx; ld_b = bw_sx;  ld_sgn = 1'b1; end
      OP_MULHW_U:              begin ld_a = aw_zx; ld_b = bw_zx; end
      OP_MULD_OV, OP_MULHD_S:  begin ld_a = a_sx;  ld_b = rs_b;   ld_sgn = 1'b1; end
      OP_MULHD_U:              begin ld_a = a_zx;  ld_b = rs_b; end
      OP_MADDH_S, OP_MADDL:    begin ld_a = a_sx;  ld_b = rs_b;   ld_c = c_sx; ld_sgn = 1'b1; end
      OP_MADDH_U:              begin ld_a = a_zx;  ld_b = rs_b;   ld_c = c_zx; end
      default: ;
    endcase
  end

  // the top multiplier bit carries negative weight in signed forms
  assign busy    = (cnt != '0);
  assign last    = (cnt == CW'(1));
  assign addend  = mplier[0] ? mcand : '0;
  assign acc_nxt = (last && sgn_q) ? acc - addend : acc + addend;

  logic [XLEN:0]   top_d;
  logic [HW:0]     top_w;
  logic [XLEN-1:0] res_nxt;
  logic            ov_nxt;

  assign top_d = acc_nxt[PW-1:XLEN-1];
  assign top_w = acc_nxt[XLEN-1:HW-1];

  always_comb begin
    res_nxt = '0;
    ov_nxt  = 1'b0;
    case (op_q)
      OP_MULI, OP_MADDL:        res_nxt = acc_nxt[XLEN-1:0];
      OP_MULHW_S, OP_MULHW_U:   res_nxt = {acc_nxt[XLEN-1:HW], acc_nxt[XLEN-1:HW]};
      OP_MULW_OV: begin
        res_nxt = acc_nxt[XLEN-1:0];
        ov_nxt  = !((&top_w) || !(|top_w));
      end
      OP_MULD_OV: begin
        res_nxt = acc_nxt[XLEN-1:0];
        ov_nxt  = !((&top_d) || !(|top_d));
      end
      OP_MULHD_S, OP_MULHD_U,
      OP_MADDH_S, OP_MADDH_U:   res_nxt = acc_nxt[PW-1:XLEN];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      op_q   <= '0;
      sgn_q  <= 1'b0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      result <= '0;
      ovf    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc    <= acc_nxt;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - CW'(1);
        if (last) begin
          result <= res_nxt;
          ovf    <= ov_nxt;
          done   <= 1'b1;
        end
      end else if (start) begin
        cnt    <= CW'(XLEN);
        op_q   <= op;
        sgn_q  <= ld_sgn;
        acc    <= ld_c;
        mcand  <= ld_a;
        mplier <= ld_b;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(ovf))); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(sgn_q))); // R3
  AST_WORD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_MULHW_S || op_q == OP_MULHW_U)) |-> (result[XLEN-1:HW] == result[HW-1:0])); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q != OP_MULW_OV && op_q != OP_MULD_OV) |-> !ovf); // R14
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q > OP_MADDL) |-> (result == '0 && !ovf)); // R13
endmodule

// File: tb/tb_mul_wide_unit.sv
`timescale 1ns/1ps
module tb_mul_wide_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] ra = '0, rb = '0, rc = '0;
  logic [15:0] imm = '0;
  logic [63:0] result;
  logic        ovf, done;

  always #2 clk = ~clk;

  mul_wide_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs_a(ra),
                     .rs_b(rb), .rs_c(rc), .imm(imm), .result(result), .ovf(ovf), .done(done));

  int checks = 0, errors = 0, cycles = 0;
  bit armed = 0;

  int          m_cnt = 0;
  logic [63:0] m_res = '0;
  logic        m_ov = 1'b0, m_done = 1'b0;
  logic [64:0] m_pend = '0;
  string       m_tag = "R1", m_ptag = "R1", cur_tag = "R2";

  localparam logic [63:0] MIN  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAX  = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NEG1 = '1;
  localparam logic [63:0] A1   = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] B1   = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] C1   = 64'h8000_0000_0000_0001;

  function automatic logic [127:0] sx(logic [63:0] v); return {{64{v[63]}}, v}; endfunction
  function automatic logic [127:0] zx(logic [63:0] v); return {64'b0, v}; endfunction
  function automatic logic [127:0] sxw(logic [63:0] v); return {{96{v[31]}}, v[31:0]}; endfunction
  function automatic logic [127:0] zxw(logic [63:0] v); return {96'b0, v[31:0]}; endfunction

  function automatic logic [64:0] ref_calc(logic [3:0] o, logic [63:0] a, logic [63:0] b,
                                           logic [63:0] c, logic [15:0] i);
    logic [127:0] x, y, z, s;
    logic [63:0]  r;
    logic         v;
    x = '0; y = '0; z = '0; r = '0; v = 1'b0;
    case (o)
      4'd0:       begin x = sx(a);  y = sx({{48{i[15]}}, i}); end
      4'd1, 4'd3: begin x = sxw(a); y = sxw(b); end
      4'd2:       begin x = zxw(a); y = zxw(b); end
      4'd4, 4'd5: begin x = sx(a);  y = sx(b); end
      4'd6:       begin x = zx(a);  y = zx(b); end
      4'd7, 4'd9: begin x = sx(a);  y = sx(b); z = sx(c); end
      4'd8:       begin x = zx(a);  y = zx(b); z = zx(c); end
      default: ;
    endcase
    s = x * y + z;
    case (o)
      4'd0, 4'd9: r = s[63:0];
      4'd1, 4'd2: r = {s[63:32], s[63:32]};
      4'd3: begin r = s[63:0];  v = !(s[63:31] == '0 || s[63:31] == {33{1'b1}}); end
      4'd4: begin r = s[63:0];  v = !(s[127:63] == '0 || s[127:63] == {65{1'b1}}); end
      4'd5, 4'd6, 4'd7, 4'd8: r = s[127:64];
      default: ;
    endcase
    return {v, r};
  endfunction

  always @(posedge clk) begin
    cycles++;
    armed = 1;
    if (!rst_n) begin
      m_cnt = 0; m_res = '0; m_ov = 1'b0; m_done = 1'b0; m_tag = "R1";
    end else begin
      if (m_done) m_tag = "R4";
      m_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1'b1;
          {m_ov, m_res} = m_pend;
          m_tag = m_ptag;
        end
      end else if (start) begin
        m_cnt  = 64;
        m_pend = ref_calc(op, ra, rb, rc, imm);
        m_ptag = cur_tag;
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk(rst_n ? "R2" : "R1", "done", {63'b0, done}, {63'b0, m_done});
      chk(m_tag, "result", result, m_res);
      chk(m_tag, "ovf", {63'b0, ovf}, {63'b0, m_ov});
    end
  end

  task automatic run(logic [3:0] o, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                     logic [15:0] i, string tag, int stray);
    @(negedge clk);
    op = o; ra = a; rb = b; rc = c; imm = i; cur_tag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (stray > 0) begin
      repeat (stray - 1) @(negedge clk);
      op = 4'd5; ra = NEG1; rb = MIN; rc = MAX; imm = 16'h1234; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_cnt != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(4'd0, A1, '0, '0, 16'h8001, "R5", 0);
    run(4'd0, NEG1, '0, '0, 16'h7FFF, "R5", 0);
    run(4'd0, MIN, '0, '0, 16'hFFFF, "R12", 0);
    run(4'd1, A1, B1, '0, '0, "R6", 0);
    run(4'd2, A1, B1, '0, '0, "R6", 0);
    run(4'd2, 64'hDEAD_0000_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, '0, '0, "R6", 0);
    run(4'd1, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_8000_0000, '0, '0, "R12", 0);
    run(4'd3, 64'h5555_0000_0001_0000, 64'h0000_0000_0000_8000, '0, '0, "R7", 0);
    run(4'd3, 64'h0000_0000_0001_0000, 64'hAAAA_0000_FFFF_8000, '0, '0, "R7", 0);
    run(4'd3, A1, B1, '0, '0, "R7", 0);
    run(4'd3, 64'h8000_0000, 64'h8000_0000, '0, '0, "R12", 0);
    run(4'd4, MAX, 64'd1, '0, '0, "R8", 0);
    run(4'd4, 64'h4000_0000_0000_0000, 64'd2, '0, '0, "R8", 0);
    run(4'd4, 64'hC000_0000_0000_0000, 64'd2, '0, '0, "R8", 0);
    run(4'd4, A1, B1, '0, '0, "R8", 0);
    run(4'd4, MIN, MIN, '0, '0, "R12", 0);
    run(4'd5, A1, B1, '0, '0, "R9", 0);
    run(4'd6, A1, B1, '0, '0, "R9", 0);
    run(4'd6, NEG1, NEG1, '0, '0, "R9", 0);
    run(4'd5, NEG1, NEG1, '0, '0, "R9", 0);
    run(4'd5, MIN, MIN, '0, '0, "R12", 0);
    run(4'd5, MIN, MAX, '0, '0, "R12", 0);
    run(4'd6, MIN, MIN, '0, '0, "R14", 0);
    run(4'd7, A1, B1, C1, '0, "R10", 0);
    run(4'd8, A1, B1, NEG1, '0, "R10", 0);
    run(4'd7, NEG1, 64'd1, NEG1, '0, "R10", 0);
    run(4'd8, NEG1, NEG1, NEG1, '0, "R10", 0);
    run(4'd7, MIN, MIN, MIN, '0, "R12", 0);
    run(4'd9, A1, B1, C1, '0, "R11", 0);
    run(4'd9, MAX, MAX, NEG1, '0, "R11", 0);
    run(4'd9, MIN, MIN, MAX, '0, "R12", 0);
    run(4'd10, A1, B1, C1, 16'h7777, "R13", 0);
    run(4'd15, NEG1, NEG1, NEG1, 16'hFFFF, "R13", 0);
    run(4'd1, MIN, MIN, NEG1, '0, "R14", 0);
    run(4'd0, A1, B1, C1, 16'h0003, "R3", 10);
    run(4'd9, B1, A1, C1, '0, "R3", 63);
    run(4'd6, A1, A1, '0, '0, "R3", 1);
    run(4'd5, B1, B1, '0, '0, "R3", 0);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule